// File: doc/BRIEF.md
# Two-Argument Arctangent Front End (Special Cases and Octant Reduction)

This block is the entry stage of a single-precision two-argument arctangent unit. It accepts a pair of IEEE754 binary32 words, y and x, over a valid/ready handshake. Each operand is sorted into one of four classes: NaN, infinity, zero or finite nonzero. Every combination that has a fixed answer is settled here: NaN propagation, the infinity cases, the signed-zero cases and operands of equal magnitude. For these the block emits the final binary32 angle and raises `special`.

For all other pairs the block reduces the problem to the first octant. It names a numerator and a denominator magnitude, the smaller one always on top, so the later core only ever evaluates an arctangent of a ratio in [0, 1). It also supplies an additive angle constant and a sign for the core's term. Downstream logic forms the final angle as `offset + (term_neg ? -1 : +1) * atan(num / den)`. The divider, the arctangent core and that final add lie outside this block.

The stage has one register of latency. A pair is taken on a clock edge where `in_valid` and `in_ready` are both high, and the result appears on the next cycle with `out_valid`. That result is held until `out_ready` takes it.

Top module: `atan2_front`

## Requirements
- R1: If x is NaN the result is x with the quiet bit (bit 22) set; otherwise, if y is NaN, the result is y with bit 22 set; x takes priority over y. Such outputs have `special`=1.
- R2: With x = +infinity, the result is π/4 (0x3F490FDB magnitude) if y is infinite, otherwise zero; in both cases bit 31 is taken from y.
- R3: With x = -infinity, the result is 3π/4 (0x4016CBE4 magnitude) if y is infinite, otherwise π (0x40490FDB magnitude); bit 31 comes from y.
- R4: With x finite (including zero) and y infinite, the result is π/2 (0x3FC90FDB magnitude) with the sign of y.
- R5: With x zero of either sign and y finite nonzero, the result is π/2 with the sign of y.
- R6: With y zero and x not NaN or infinite, the result is zero with the sign of y when x's sign bit is 0, and π with the sign of y when x's sign bit is 1.
- R7: For finite nonzero operands with |y| < |x| (comparing bits 30:0 as unsigned), `num` = |y| and `den` = |x| (sign bits 0). If x > 0, `offset` = zero and `term_neg` = sign of y. If x < 0, `offset` = π and `term_neg` = NOT sign of y. In both cases the offset's sign bit equals y's sign.
- R8: For finite nonzero operands with |y| > |x|, `num` = |x`|` and `den` = |y|, `offset` = π/2 with the sign of y, and `term_neg` = 1 when the signs of x and y are equal.
- R9: For finite nonzero operands with |y| = |x|, the result is π/4 with the sign of y if x > 0, or 3π/4 with the sign of y if x < 0, with `special`=1.
- R10: Subnormal operands are handled as finite nonzero values in every rule above.
- R11: `in_ready` is high when `out_valid` is low or `out_ready` is high. An accepted pair produces `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and new input is not taken.
- R12: When `special`=1, `num`, `den` and `offset` are zero and `term_neg` is 0. When `special`=0, `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Stage can take a pair this cycle |
| y_in | input | 32 | Operand y (binary32) |
| x_in | input | 32 | Operand x (binary32) |
| out_valid | output | 1 | Output fields hold a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| special | output | 1 | Final angle is on `result`; no core evaluation is needed |
| result | output | 32 | Final binary32 angle when `special` is 1 |
| num | output | 32 | Numerator magnitude for the core |
| den | output | 32 | Denominator magnitude for the core |
| offset | output | 32 | Angle constant added to the core term |
| term_neg | output | 1 | Subtract the core term instead of adding it |

## Verification
The bench targets the order of the decision table. If the x NaN check lost priority, a pair with two NaNs would return y's payload. If the infinity checks sat below the zero checks, a pair with x = -infinity and y = -0 could be sent down the wrong branch. The signed-zero cases are run with both zero signs on each side. A design that tested a zero x by value instead of by sign bit would return +0 where ±π is due. Quadrant checks use all four sign pairings in each ratio orientation, so an inverted term sign or a missing π offset shows up directly. Equal magnitudes, subnormal operands and a stall under back-pressure cover the comparator boundary, the classifier and the output hold.

// File: rtl/atan2_fe_pkg.sv
package atan2_fe_pkg;
  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int MAG_W  = FP_W - 1;
  localparam int QUIET_BIT = FRAC_W - 1;

  typedef enum logic [1:0] {
    CLS_ZERO   = 2'd0,
    CLS_FINITE = 2'd1,
    CLS_INF    = 2'd2,
    CLS_NAN    = 2'd3
  } fp_cls_e;

  // Round-to-nearest binary32 magnitudes of the angle constants
  localparam logic [MAG_W-1:0] MAG_ZERO   = '0;
  localparam logic [MAG_W-1:0] MAG_QTR_PI = 31'h3F490FDB;
  localparam logic [MAG_W-1:0] MAG_HALF_PI = 31'h3FC90FDB;
  localparam logic [MAG_W-1:0] MAG_3QTR_PI = 31'h4016CBE4;
  localparam logic [MAG_W-1:0] MAG_PI     = 31'h40490FDB;
endpackage

// File: rtl/fp_classify.sv
module fp_classify
  import atan2_fe_pkg::*;
#(
  parameter int W  = FP_W,
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W
) (
  input  logic [W-1:0]   word,
  output fp_cls_e        cls,
  output logic           sgn,
  output logic [W-2:0]   mag
);
  logic [EW-1:0] expo;
  logic [FW-1:0] frac;

  assign expo = word[W-2 -: EW];
  assign frac = word[FW-1:0];
  assign sgn  = word[W-1];
  assign mag  = word[W-2:0];

  always_comb begin
    if (expo == {EW{1'b1}})
      cls = (frac != '0) ? CLS_NAN : CLS_INF;
    else if (expo == '0 && frac == '0)
      cls = CLS_ZERO;
    else
      cls = CLS_FINITE; // subnormals included
  end
endmodule

// File: rtl/special_resolve.sv
module special_resolve
  import atan2_fe_pkg::*;
(
  input  logic [FP_W-1:0]  y_word,
  input  logic [FP_W-1:0]  x_word,
  input  fp_cls_e          y_cls,
  input  fp_cls_e          x_cls,
  input  logic             mag_equal,
  output logic             is_special,
  output logic [FP_W-1:0]  spec_result
);
  logic sy, sx;
  logic [FP_W-1:0] quiet_mask;

  assign sy = y_word[FP_W-1];
  assign sx = x_word[FP_W-1];
  assign quiet_mask = FP_W'(1) << QUIET_BIT;

  always_comb begin
    is_special  = 1'b1;
    spec_result = '0;
    if (x_cls == CLS_NAN) begin
      spec_result = x_word | quiet_mask;
    end else if (y_cls == CLS_NAN) begin
      spec_result = y_word | quiet_mask;
    end else if (x_cls == CLS_INF && !sx) begin
      spec_result = {sy, (y_cls == CLS_INF) ? MAG_QTR_PI : MAG_ZERO};
    end else if (x_cls == CLS_INF) begin
      spec_result = {sy, (y_cls == CLS_INF) ? MAG_3QTR_PI : MAG_PI};
    end else if (y_cls == CLS_INF) begin
      spec_result = {sy, MAG_HALF_PI};
    end else if (x_cls == CLS_ZERO && y_cls != CLS_ZERO) begin
      spec_result = {sy, MAG_HALF_PI};
    end else if (y_cls == CLS_ZERO) begin
      spec_result = {sy, sx ? MAG_PI : MAG_ZERO};
    end else if (mag_equal) begin
      spec_result = {sy, sx ? MAG_3QTR_PI : MAG_QTR_PI};
    end else begin
      is_special = 1'b0;
    end
  end
endmodule

// File: rtl/octant_select.sv
module octant_select
  import atan2_fe_pkg::*;
(
  input  logic             sy,
  input  logic             sx,
  input  logic [MAG_W-1:0] y_mag,
  input  logic [MAG_W-1:0] x_mag,
  output logic             mag_equal,
  output logic [FP_W-1:0]  num_o,
  output logic [FP_W-1:0]  den_o,
  output logic [FP_W-1:0]  offset_o,
  output logic             neg_o
);
  logic y_not_above;

  assign y_not_above = (y_mag <= x_mag);
  assign mag_equal   = (y_mag == x_mag);

  always_comb begin
    if (y_not_above) begin
      num_o    = {1'b0, y_mag};
      den_o    = {1'b0, x_mag};
      offset_o = {sy, sx ? MAG_PI : MAG_ZERO};
      neg_o    = sx ? ~sy : sy;
    end else begin
      num_o    = {1'b0, x_mag};
      den_o    = {1'b0, y_mag};
      offset_o = {sy, MAG_HALF_PI};
      neg_o    = (sx == sy);
    end
  end
endmodule

// File: rtl/atan2_front.sv
module atan2_front
  import atan2_fe_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     y_in,
  input  logic [31:0]     x_in,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            special,
  output logic [31:0]     result,
  output logic [31:0]     num,
  output logic [31:0]     den,
  output logic [31:0]     offset,
  output logic            term_neg
);
  localparam int N_OPS = 2;

  logic [FP_W-1:0]  op_word [N_OPS];
  fp_cls_e          op_cls  [N_OPS];
  logic             op_sgn  [N_OPS];
  logic [MAG_W-1:0] op_mag  [N_OPS];

  assign op_word[0] = y_in;
  assign op_word[1] = x_in;

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    fp_classify #(.W(FP_W), .EW(EXP_W), .FW(FRAC_W)) u_cls (
      .word (op_word[i]),
      .cls  (op_cls[i]),
      .sgn  (op_sgn[i]),
      .mag  (op_mag[i])
    );
  end

  logic            mag_eq;
  logic [FP_W-1:0] c_num, c_den, c_off;
  logic            c_neg;
  logic            c_spec;
  logic [FP_W-1:0] c_res;

  octant_select u_oct (
    .sy        (op_sgn[0]),
    .sx        (op_sgn[1]),
    .y_mag     (op_mag[0]),
    .x_mag     (op_mag[1]),
    .mag_equal (mag_eq),
    .num_o     (c_num),
    .den_o     (c_den),
    .offset_o  (c_off),
    .neg_o     (c_neg)
  );

  special_resolve u_spec (
    .y_word      (y_in),
    .x_word      (x_in),
    .y_cls       (op_cls[0]),
    .x_cls       (op_cls[1]),
    .mag_equal   (mag_eq),
    .is_special  (c_spec),
    .spec_result (c_res)
  );

  logic take;
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      special   <= 1'b0;
      result    <= '0;
      num       <= '0;
      den       <= '0;
      offset    <= '0;
      term_neg  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      special   <= c_spec;
      result    <= c_spec ? c_res : '0;
      num       <= c_spec ? '0 : c_num;
      den       <= c_spec ? '0 : c_den;
      offset    <= c_spec ? '0 : c_off;
      term_neg  <= c_spec ? 1'b0 : c_neg;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/atan2_front_checker.sv
module atan2_front_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] x_in,
  input logic        out_valid,
  input logic        out_ready,
  input logic        special,
  input logic [31:0] result,
  input logic [31:0] num,
  input logic [31:0] den,
  input logic [31:0] offset,
  input logic        term_neg
);
  logic x_is_nan;
  assign x_is_nan = (x_in[30:23] == 8'hFF) && (x_in[22:0] != '0);

  // R7 R8: the core never sees a ratio above one
  assert_ratio_le_one_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !special) |-> (!num[31] && !den[31] && num[30:0] <= den[30:0]));

  // R8: offsets limited to zero, pi/2 and pi
  assert_offset_set_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !special) |->
      (offset[30:0] == 31'h0 || offset[30:0] == 31'h3FC90FDB || offset[30:0] == 31'h40490FDB));

  // R1: NaN in x is returned quieted
  assert_x_nan_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && x_is_nan) |=>
      (out_valid && special && result == ($past(x_in) | 32'h0040_0000)));

  // R11: held output under back-pressure
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(result) && $stable(num) && $stable(special) && $stable(offset)));

  // R11: accepted pair appears next cycle
  assert_accept_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R12: special outputs leave the core fields clear
  assert_special_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && special) |-> (num == '0 && den == '0 && offset == '0 && !term_neg));
endmodule

bind atan2_front atan2_front_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .x_in      (x_in),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .special   (special),
  .result    (result),
  .num       (num),
  .den       (den),
  .offset    (offset),
  .term_neg  (term_neg)
);

// File: tb/sim_atan2_front.sv
`timescale 1ns/1ps
module sim_atan2_front;
  localparam logic [31:0] P4  = 32'h3F490FDB;
  localparam logic [31:0] P2  = 32'h3FC90FDB;
  localparam logic [31:0] P34 = 32'h4016CBE4;
  localparam logic [31:0] PI  = 32'h40490FDB;
  localparam logic [31:0] NEG = 32'h8000_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000;
  localparam logic [31:0] TWO = 32'h4000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000;
  localparam logic [31:0] NINF = 32'hFF80_0000;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [31:0] y_in, x_in, result, num, den, offset;
  logic special, term_neg;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  atan2_front u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .y_in(y_in), .x_in(x_in), .out_valid(out_valid), .out_ready(out_ready),
    .special(special), .result(result), .num(num), .den(den),
    .offset(offset), .term_neg(term_neg)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive one pair, sample at the following falling edge
  task automatic apply(logic [31:0] y, logic [31:0] x);
    @(negedge clk);
    y_in = y; x_in = x; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_spec(string req, logic [31:0] y, logic [31:0] x, logic [31:0] exp);
    apply(y, x);
    check({req, " valid"}, {31'h0, out_valid}, 32'h1);
    check({req, " special"}, {31'h0, special}, 32'h1);
    check({req, " result"}, result, exp);
  endtask

  task automatic expect_core(string req, logic [31:0] y, logic [31:0] x,
                             logic [31:0] en, logic [31:0] ed, logic [31:0] eo, logic eneg);
    apply(y, x);
    check({req, " special"}, {31'h0, special}, 32'h0);
    check({req, " num"}, num, en);
    check({req, " den"}, den, ed);
    check({req, " offset"}, offset, eo);
    check({req, " term_neg"}, {31'h0, term_neg}, {31'h0, eneg});
    check({req, " result zero R12"}, result, 32'h0);
  endtask

  task automatic t_reset();
    check("R11 reset out_valid", {31'h0, out_valid}, 32'h0);
    check("R11 reset in_ready", {31'h0, in_ready}, 32'h1);
  endtask

  task automatic t_nan();
    expect_spec("R1 both nan", 32'h7FC12345, 32'h7F800005, 32'h7FC00005);
    expect_spec("R1 y nan", 32'hFF800003, ONE, 32'hFFC00003);
    expect_spec("R1 x nan y inf", PINF, 32'hFFC00001, 32'hFFC00001);
  endtask

  task automatic t_pos_inf();
    expect_spec("R2 inf inf", PINF, PINF, P4);
    expect_spec("R2 -inf inf", NINF, PINF, NEG | P4);
    expect_spec("R2 finite", NEG | TWO, PINF, NEG);
    expect_spec("R2 zero", 32'h0, PINF, 32'h0);
  endtask

  task automatic t_neg_inf();
    expect_spec("R3 -inf -inf", NINF, NINF, NEG | P34);
    expect_spec("R3 finite", TWO, NINF, PI);
    expect_spec("R3 neg zero", NEG, NINF, NEG | PI);
  endtask

  task automatic t_y_inf();
    expect_spec("R4 x neg", PINF, NEG | TWO, P2);
    expect_spec("R4 x zero", NINF, 32'h0, NEG | P2);
  endtask

  task automatic t_x_zero();
    expect_spec("R5 -y -0", NEG | TWO, NEG, NEG | P2);
    expect_spec("R5 +y +0", ONE, 32'h0, P2);
  endtask

  task automatic t_y_zero();
    expect_spec("R6 +0 +0", 32'h0, 32'h0, 32'h0);
    expect_spec("R6 -0 +0", NEG, 32'h0, NEG);
    expect_spec("R6 +0 -0", 32'h0, NEG, PI);
    expect_spec("R6 -0 neg", NEG, NEG | TWO, NEG | PI);
    expect_spec("R6 -0 pos", NEG, ONE, NEG);
  endtask

  task automatic t_small_y();
    expect_core("R7 q1", ONE, TWO, ONE, TWO, 32'h0, 1'b0);
    expect_core("R7 q4", NEG | ONE, TWO, ONE, TWO, NEG, 1'b1);
    expect_core("R7 q2", ONE, NEG | TWO, ONE, TWO, PI, 1'b1);
    expect_core("R7 q3", NEG | ONE, NEG | TWO, ONE, TWO, NEG | PI, 1'b0);
  endtask

  task automatic t_large_y();
    expect_core("R8 q1", TWO, ONE, ONE, TWO, P2, 1'b1);
    expect_core("R8 q2", TWO, NEG | ONE, ONE, TWO, P2, 1'b0);
    expect_core("R8 q4", NEG | TWO, ONE, ONE, TWO, NEG | P2, 1'b0);
    expect_core("R8 q3", NEG | TWO, NEG | ONE, ONE, TWO, NEG | P2, 1'b1);
  endtask

  task automatic t_equal();
    expect_spec("R9 pos pos", ONE, ONE, P4);
    expect_spec("R9 neg neg", NEG | ONE, NEG | ONE, NEG | P34);
    expect_spec("R9 pos neg", ONE, NEG | ONE, P34);
  endtask

  task automatic t_subnormal();
    expect_core("R10 sub ratio", 32'h1, 32'h2, 32'h1, 32'h2, 32'h0, 1'b0);
    expect_spec("R10 sub over zero", 32'h3, 32'h0, P2);
    expect_spec("R10 sub equal", 32'h5, NEG | 32'h5, P34);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0; y_in = ONE; x_in = TWO; in_valid = 1'b1;
    @(negedge clk);
    check("R11 stall valid", {31'h0, out_valid}, 32'h1);
    check("R11 stall ready low", {31'h0, in_ready}, 32'h0);
    y_in = TWO; x_in = ONE;
    @(negedge clk);
    check("R11 stall held offset", offset, 32'h0);
    check("R11 stall held num", num, ONE);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 second taken", offset, P2);
    check("R11 second valid", {31'h0, out_valid}, 32'h1);
    @(negedge clk);
    check("R11 drained", {31'h0, out_valid}, 32'h0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; y_in = '0; x_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nan();
    t_pos_inf();
    t_neg_inf();
    t_y_inf();
    t_x_zero();
    t_y_zero();
    t_small_y();
    t_large_y();
    t_equal();
    t_subnormal();
    t_stall();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule